// File: doc/BRIEF.md
# SD Card Clock Divider with Identification/Data Mode Switch

This block derives the SD card clock from the core clock. A divider register holds the division ratio minus two. A ratio of `value + 2` core cycles makes one SD clock period. Two divisors are available. In identification mode the full register is used. In data mode only its low bits are used, which gives a short, fast ratio. A slow-card level keeps the identification divisor in force in every mode, so that the fast divisor can be avoided when the core clock is too high for it.

The controller state machine enters data mode with a one-cycle request. The block watches each issued command index, and index 15 sends it back to identification mode. Alongside the SD clock, the block produces one-cycle rising and falling strobes for the command and data shifters. A new ratio, whether it comes from a register write or a mode change, is applied only when the SD clock enters its low phase. A high pulse already in progress is therefore never cut short.

Top module: `sdclk_divider`

## Requirements
- R1: In identification mode the SD clock period is `divValue + 2` core cycles, where `divValue` is the last value written through `divWrEn`/`divWrData`.
- R2: For a ratio N, the high phase lasts floor(N/2) core cycles and the low phase lasts ceil(N/2) core cycles. An odd ratio therefore has a high phase one cycle shorter than its low phase.
- R3: The largest value, 0x7FF, gives a period of 2049 cycles (1024 high, 1025 low). The clock keeps toggling at every setting.
- R4: In data mode, with `slowCard` low, the ratio is `divValue[2:0] + 2`.
- R5: With `slowCard` high, the ratio is `divValue + 2` even in data mode.
- R6: During and after reset, `sdClk`, `riseStb`, `fallStb` and `inDataMode` are 0, and the divider value is 507, so the settled period is 254 cycles high and 255 cycles low.
- R7: An `enterData` pulse sets `inDataMode` on the next cycle. A `cmdValid` with `cmdIdx` equal to 15 clears it. Any other index has no effect. When both arrive in the same cycle, identification mode wins.
- R8: A change of divider value or mode takes effect only at the start of the next low phase. A high phase in progress keeps its old length.
- R9: `riseStb` is high for exactly the first cycle in which `sdClk` reads 1, and `fallStb` for exactly the first cycle in which it reads 0. The two are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rstN | input | 1 | Active-low synchronous reset |
| divWrEn | input | 1 | Load strobe for the divider value |
| divWrData | input | 11 | New divider value (ratio minus two) |
| slowCard | input | 1 | Keep the identification divisor in every mode |
| enterData | input | 1 | One-cycle request to enter data mode |
| cmdValid | input | 1 | A command is being issued |
| cmdIdx | input | 6 | Index of the command being issued |
| sdClk | output | 1 | SD card clock |
| riseStb | output | 1 | First core cycle of an SD clock high phase |
| fallStb | output | 1 | First core cycle of an SD clock low phase |
| inDataMode | output | 1 | 1 while the data-mode divisor is selected |

## Verification
The hardest situation to reach from the ports is a ratio change that lands in the middle of a high phase, since that is where a runt pulse would appear. The bench locks onto the rising strobe, writes a much smaller ratio in that same cycle, and then counts the rest of the high phase and the low phase that follows. It also issues a return command together with a data-mode request in the same cycle, and a command with a different index while in data mode. In both cases it confirms the outcome through the mode output and the measured period.

// File: rtl/sdclk_pkg.sv
package sdclk_pkg;

  // Phase events the control sends to the datapath in one cycle
  typedef struct packed {
    logic goHigh;   // SD clock enters its high phase on this edge
    logic goLow;    // SD clock enters its low phase; latch the new ratio
    logic useFast;  // short data-mode divisor currently selected
  } phase_cmd_t;

endpackage

// File: rtl/sdclk_phase_ctrl.sv
module sdclk_phase_ctrl
  import sdclk_pkg::*;
#(
  parameter int CNT_W      = 12,
  parameter int IDX_W      = 6,
  parameter int RETURN_IDX = 15,
  parameter int RESET_LOW  = 255
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             enterData,
  input  logic             cmdValid,
  input  logic [IDX_W-1:0] cmdIdx,
  input  logic             slowCard,
  input  logic [CNT_W-1:0] nextLowLen,
  input  logic [CNT_W-1:0] curHighLen,
  output phase_cmd_t       phaseCmd,
  output logic             dataMode
);

  localparam logic [IDX_W-1:0] RET_IDX = IDX_W'(RETURN_IDX);
  localparam logic [CNT_W-1:0] CNT_RST = CNT_W'(RESET_LOW - 1);

  logic [CNT_W-1:0] phaseCnt;
  logic             inHigh;
  logic             returnCmd;
  logic             phaseEnd;

  assign returnCmd = cmdValid && (cmdIdx == RET_IDX);
  assign phaseEnd  = (phaseCnt == '0);

  always_comb begin
    phaseCmd.goHigh  = phaseEnd && !inHigh;
    phaseCmd.goLow   = phaseEnd && inHigh;
    phaseCmd.useFast = dataMode && !slowCard;
  end

  // Mode tracking: the return command has priority over a data request
  always_ff @(posedge clk) begin
    if (!rstN) begin
      dataMode <= 1'b0;
    end else if (returnCmd) begin
      dataMode <= 1'b0;
    end else if (enterData) begin
      dataMode <= 1'b1;
    end
  end

  // Phase counter: counts down the cycles left in the current phase
  always_ff @(posedge clk) begin
    if (!rstN) begin
      phaseCnt <= CNT_RST;
      inHigh   <= 1'b0;
    end else if (phaseCmd.goHigh) begin
      phaseCnt <= curHighLen - CNT_W'(1);
      inHigh   <= 1'b1;
    end else if (phaseCmd.goLow) begin
      phaseCnt <= nextLowLen - CNT_W'(1);
      inHigh   <= 1'b0;
    end else begin
      phaseCnt <= phaseCnt - CNT_W'(1);
    end
  end

  AST_MODE_RETURN: assert property (@(posedge clk) disable iff (!rstN)
    returnCmd |=> !dataMode); // R7

  AST_MODE_ENTER: assert property (@(posedge clk) disable iff (!rstN)
    (enterData && !returnCmd) |=> dataMode); // R7

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!enterData && !returnCmd) |=> $stable(dataMode)); // R7

  AST_HIGH_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    inHigh |-> (phaseCnt < curHighLen)); // R8

  AST_LEN_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    (nextLowLen != '0) && (curHighLen != '0)); // R3

endmodule

// File: rtl/sdclk_ratio_path.sv
module sdclk_ratio_path
  import sdclk_pkg::*;
#(
  parameter int DIV_W     = 11,
  parameter int FAST_W    = 3,
  parameter int RESET_DIV = 507,
  parameter int CNT_W     = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  phase_cmd_t       phaseCmd,
  output logic [CNT_W-1:0] nextLowLen,
  output logic [CNT_W-1:0] curHighLen,
  output logic             sdClk,
  output logic             riseStb,
  output logic             fallStb
);

  localparam int               RESET_RATIO = RESET_DIV + 2;
  localparam logic [CNT_W-1:0] HIGH_RST    = CNT_W'(RESET_RATIO / 2);

  logic [DIV_W-1:0] divReg;
  logic [CNT_W-1:0] selVal;
  logic [CNT_W-1:0] ratio;
  logic [CNT_W-1:0] nextHighLen;
  logic [CNT_W-1:0] highLatch;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divReg <= DIV_W'(RESET_DIV);
    end else if (divWrEn) begin
      divReg <= divWrData;
    end
  end

  // Divisor selection: the fast variant keeps only the low bits
  always_comb begin
    if (phaseCmd.useFast) begin
      selVal = CNT_W'(divReg[FAST_W-1:0]);
    end else begin
      selVal = CNT_W'(divReg);
    end
    ratio       = selVal + CNT_W'(2);
    nextHighLen = ratio >> 1;
    nextLowLen  = ratio - nextHighLen;
  end

  assign curHighLen = highLatch;

  // The high length is captured only as the clock drops low
  always_ff @(posedge clk) begin
    if (!rstN) begin
      highLatch <= HIGH_RST;
    end else if (phaseCmd.goLow) begin
      highLatch <= nextHighLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sdClk   <= 1'b0;
      riseStb <= 1'b0;
      fallStb <= 1'b0;
    end else begin
      riseStb <= phaseCmd.goHigh;
      fallStb <= phaseCmd.goLow;
      if (phaseCmd.goHigh) begin
        sdClk <= 1'b1;
      end else if (phaseCmd.goLow) begin
        sdClk <= 1'b0;
      end
    end
  end

  AST_DIV_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    divWrEn |=> (divReg == $past(divWrData))); // R1

  AST_HIGH_ONLY_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(highLatch) |-> $past(phaseCmd.goLow)); // R8

  AST_RISE_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    riseStb |-> (sdClk && !$past(sdClk))); // R9

  AST_FALL_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    fallStb |-> (!sdClk && $past(sdClk))); // R9

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    !(riseStb && fallStb)); // R9

  AST_ODD_SPLIT: assert property (@(posedge clk) disable iff (!rstN)
    (nextLowLen == nextHighLen) || (nextLowLen == nextHighLen + CNT_W'(1))); // R2

endmodule

// File: rtl/sdclk_divider.sv
module sdclk_divider
  import sdclk_pkg::*;
#(
  parameter int DIV_W      = 11,
  parameter int FAST_W     = 3,
  parameter int RESET_DIV  = 507,
  parameter int IDX_W      = 6,
  parameter int RETURN_IDX = 15
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             divWrEn,
  input  logic [DIV_W-1:0] divWrData,
  input  logic             slowCard,
  input  logic             enterData,
  input  logic             cmdValid,
  input  logic [IDX_W-1:0] cmdIdx,
  output logic             sdClk,
  output logic             riseStb,
  output logic             fallStb,
  output logic             inDataMode
);

  localparam int CNT_W       = DIV_W + 1;
  localparam int RESET_RATIO = RESET_DIV + 2;
  localparam int RESET_LOW   = RESET_RATIO - RESET_RATIO / 2;

  phase_cmd_t       phaseCmd;
  logic [CNT_W-1:0] nextLowLen;
  logic [CNT_W-1:0] curHighLen;

  sdclk_phase_ctrl #(
    .CNT_W      (CNT_W),
    .IDX_W      (IDX_W),
    .RETURN_IDX (RETURN_IDX),
    .RESET_LOW  (RESET_LOW)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .enterData  (enterData),
    .cmdValid   (cmdValid),
    .cmdIdx     (cmdIdx),
    .slowCard   (slowCard),
    .nextLowLen (nextLowLen),
    .curHighLen (curHighLen),
    .phaseCmd   (phaseCmd),
    .dataMode   (inDataMode)
  );

  sdclk_ratio_path #(
    .DIV_W      (DIV_W),
    .FAST_W     (FAST_W),
    .RESET_DIV  (RESET_DIV),
    .CNT_W      (CNT_W)
  ) u_path (
    .clk        (clk),
    .rstN       (rstN),
    .divWrEn    (divWrEn),
    .divWrData  (divWrData),
    .phaseCmd   (phaseCmd),
    .nextLowLen (nextLowLen),
    .curHighLen (curHighLen),
    .sdClk      (sdClk),
    .riseStb    (riseStb),
    .fallStb    (fallStb)
  );

endmodule

// File: tb/sdclk_divider_test.sv
`timescale 1ns/1ps
module sdclk_divider_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        divWrEn = 1'b0;
  logic [10:0] divWrData = '0;
  logic        slowCard = 1'b0;
  logic        enterData = 1'b0;
  logic        cmdValid = 1'b0;
  logic [5:0]  cmdIdx = '0;
  logic        sdClk, riseStb, fallStb, inDataMode;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  sdclk_divider uut (
    .clk(clk), .rstN(rstN), .divWrEn(divWrEn), .divWrData(divWrData),
    .slowCard(slowCard), .enterData(enterData), .cmdValid(cmdValid),
    .cmdIdx(cmdIdx), .sdClk(sdClk), .riseStb(riseStb), .fallStb(fallStb),
    .inDataMode(inDataMode)
  );

  typedef struct packed {
    logic        slow;
    logic        data;
    logic [10:0] div;
    logic [11:0] expHi;
    logic [11:0] expLo;
  } vec_t;

  // Expected phase lengths worked out from the requirements
  localparam vec_t VECS [9] = '{
    '{1'b0, 1'b0, 11'd0,     12'd1,    12'd1},    // R1 ratio 2
    '{1'b0, 1'b0, 11'd1,     12'd1,    12'd2},    // R2 ratio 3
    '{1'b0, 1'b0, 11'd5,     12'd3,    12'd4},    // R2 ratio 7
    '{1'b0, 1'b0, 11'h7FF,   12'd1024, 12'd1025}, // R3 max
    '{1'b0, 1'b1, 11'h7FF,   12'd4,    12'd5},    // R4 low bits 7
    '{1'b0, 1'b1, 11'h00A,   12'd2,    12'd2},    // R4 low bits 2
    '{1'b0, 1'b1, 11'd507,   12'd2,    12'd3},    // R4 low bits 3
    '{1'b1, 1'b1, 11'h00A,   12'd6,    12'd6},    // R5 forced ident
    '{1'b1, 1'b0, 11'd20,    12'd11,   12'd11}    // R5 ident anyway
  };

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Syncs to a fall strobe, then counts one low and one high phase
  task automatic measure(output int hi, output int lo, output int nR, output int nF);
    do @(negedge clk); while (!fallStb);
    lo = 0; hi = 0; nR = 0; nF = 0;
    while (sdClk == 1'b0) begin
      lo++;
      if (fallStb) nF++;
      if (riseStb) nR++;
      @(negedge clk);
    end
    while (sdClk == 1'b1) begin
      hi++;
      if (riseStb) nR++;
      if (fallStb) nF++;
      @(negedge clk);
    end
  endtask

  task automatic writeDiv(input logic [10:0] v);
    divWrData = v;
    divWrEn = 1'b1;
    @(negedge clk);
    divWrEn = 1'b0;
  endtask

  task automatic setMode(input logic toData);
    if (toData) enterData = 1'b1;
    else begin cmdValid = 1'b1; cmdIdx = 6'd15; end
    @(negedge clk);
    enterData = 1'b0;
    cmdValid = 1'b0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hi, lo, nR, nF;
    repeat (3) @(negedge clk);
    // R6 reset state
    chk("R6 sdClk in reset", int'(sdClk), 0);
    chk("R6 riseStb in reset", int'(riseStb), 0);
    chk("R6 fallStb in reset", int'(fallStb), 0);
    chk("R6 mode in reset", int'(inDataMode), 0);
    rstN = 1'b1;
    measure(hi, lo, nR, nF);
    chk("R6 default high", hi, 254);
    chk("R6 default low", lo, 255);

    foreach (VECS[i]) begin
      slowCard = VECS[i].slow;
      writeDiv(VECS[i].div);
      if (VECS[i].data != inDataMode) setMode(VECS[i].data);
      measure(hi, lo, nR, nF);
      measure(hi, lo, nR, nF);
      chk($sformatf("R1/R2 vec%0d high", i), hi, int'(VECS[i].expHi));
      chk($sformatf("R1/R2 vec%0d low", i), lo, int'(VECS[i].expLo));
      chk($sformatf("R9 vec%0d rise count", i), nR, 1);
      chk($sformatf("R9 vec%0d fall count", i), nF, 1);
    end

    // R8: shrink the ratio during a high phase
    slowCard = 1'b0;
    setMode(1'b0);
    writeDiv(11'd5);
    measure(hi, lo, nR, nF);
    do @(negedge clk); while (!riseStb);
    divWrData = 11'd0;
    divWrEn = 1'b1;
    hi = 0;
    while (sdClk == 1'b1) begin
      hi++;
      @(negedge clk);
      divWrEn = 1'b0;
    end
    lo = 0;
    while (sdClk == 1'b0) begin
      lo++;
      @(negedge clk);
    end
    chk("R8 high kept old length", hi, 3);
    chk("R8 next low uses new ratio", lo, 1);

    // R7: other index ignored in data mode
    writeDiv(11'h00A);
    setMode(1'b1);
    chk("R7 enter data", int'(inDataMode), 1);
    cmdValid = 1'b1;
    cmdIdx = 6'd12;
    @(negedge clk);
    cmdValid = 1'b0;
    chk("R7 idx 12 ignored mode", int'(inDataMode), 1);
    measure(hi, lo, nR, nF);
    measure(hi, lo, nR, nF);
    chk("R7 idx 12 ignored period", hi + lo, 4);

    // R7: return command beats a data request in the same cycle
    enterData = 1'b1;
    cmdValid = 1'b1;
    cmdIdx = 6'd15;
    @(negedge clk);
    enterData = 1'b0;
    cmdValid = 1'b0;
    chk("R7 return wins", int'(inDataMode), 0);
    measure(hi, lo, nR, nF);
    measure(hi, lo, nR, nF);
    chk("R7 ident period after return", hi + lo, 12);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule